// File: doc/BRIEF.md
# Serial FIFO Pair with Fill-Level Triggers

This block holds the character queues of a serial port controller. It contains two first-in first-out buffers of 16 entries that share one clock. The transmit queue stores bytes on their way to the serializer. The receive queue stores each received byte together with four error flags that belong to that character, so the flags reach software along with the data.

Each queue produces empty and full flags, its current fill count and a trigger output. A 6-bit select input sets a threshold for each direction. The threshold is one of five fractions of the depth. The receive trigger fires when enough characters are waiting to be read. The transmit trigger fires when the queue has drained far enough to accept more characters. Both triggers are meant to drive a separate interrupt block.

A push into a full queue is dropped and reported by a one-cycle overflow pulse. A pop from an empty queue is ignored. Read data is registered: the entry at the head moves to the output register in the clock edge that pops it.

Top module: `serial_fifo_pair`

## Requirements
- R1: While reset is active and after it is released: both counts are 0, both empty flags are 1, both full flags are 0, both read outputs are 0 and both overflow pulses are 0.
- R2: Each queue holds up to 16 entries and returns them in push order. An accepted push adds 1 to the count and an accepted pop subtracts 1. After the clock edge of the pop, the popped entry is on the read output.
- R3: In the receive readout, bits 7:0 hold the data byte. Bits 11, 10, 9 and 8 hold the error input bits 3 (overrun), 2 (break), 1 (parity) and 0 (framing).
- R4: The empty flag is 1 exactly when the count is 0. The full flag is 1 exactly when the count is 16.
- R5: The transmit level code is level_sel bits 2:0 and the receive level code is level_sel bits 5:3. Codes 0, 1, 2, 3 and 4 select 2, 4, 8, 12 and 14 entries. Codes 5 to 7 act like code 4. An all-zero select gives 2 entries in both directions.
- R6: rx_trig is 1 exactly when the receive count is at or above the receive level.
- R7: tx_trig is 1 exactly when the transmit count is at or below the transmit level.
- R8: A push into a full queue is dropped, even when a pop arrives in the same cycle. The count and the stored entries do not change from the push. The overflow output of that queue is 1 for the single cycle after the edge.
- R9: A pop from an empty queue leaves the count at 0 and keeps the previous read output value.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged. The pop returns the head entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_sel | input | 6 | Trigger level codes: transmit in 2:0, receive in 5:3 |
| tx_push | input | 1 | Write tx_wdata into the transmit queue |
| tx_wdata | input | 8 | Transmit byte |
| tx_pop | input | 1 | Take the head entry of the transmit queue |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 5 | Transmit fill count |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_trig | output | 1 | Transmit count at or below its level |
| tx_ovf | output | 1 | One-cycle pulse after a dropped transmit push |
| rx_push | input | 1 | Write a received character into the receive queue |
| rx_wdata | input | 8 | Received byte |
| rx_werr | input | 4 | Error flags: overrun, break, parity, framing (bit 3 to bit 0) |
| rx_pop | input | 1 | Take the head entry of the receive queue |
| rx_rdata | output | 12 | Last entry popped from the receive queue: errors in 11:8, data in 7:0 |
| rx_count | output | 5 | Receive fill count |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_trig | output | 1 | Receive count at or above its level |
| rx_ovf | output | 1 | One-cycle pulse after a dropped receive push |

## Verification
The assertions assume that push, pop and level_sel are driven to known values on every clock edge once reset has been released. They also assume that level_sel may change at any time, because the triggers are combinational. The bench drives every input shortly after a rising edge and holds it through the next edge. It sets level_sel only while push and pop are idle. It deliberately pushes into full queues and pops from empty ones, so that the overflow and empty-read properties are exercised on legal stimulus and are not avoided.

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4,
  parameter int SEL_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*SEL_W-1:0]        level_sel,
  input  logic                      tx_push,
  input  logic [DATA_W-1:0]         tx_wdata,
  input  logic                      tx_pop,
  output logic [DATA_W-1:0]         tx_rdata,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic                      tx_empty,
  output logic                      tx_full,
  output logic                      tx_trig,
  output logic                      tx_ovf,
  input  logic                      rx_push,
  input  logic [DATA_W-1:0]         rx_wdata,
  input  logic [ERR_W-1:0]          rx_werr,
  input  logic                      rx_pop,
  output logic [ERR_W+DATA_W-1:0]   rx_rdata,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                      rx_empty,
  output logic                      rx_full,
  output logic                      rx_trig,
  output logic                      rx_ovf
);
  // DEPTH must be a power of two and at least 8 so the pointers wrap on their own.
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int AW   = $clog2(DEPTH);
  localparam int RX_W = ERR_W + DATA_W;

  function automatic logic [CW-1:0] level_of(input logic [SEL_W-1:0] code);
    case (code)
      SEL_W'(0): return CW'(DEPTH / 8);
      SEL_W'(1): return CW'(DEPTH / 4);
      SEL_W'(2): return CW'(DEPTH / 2);
      SEL_W'(3): return CW'(DEPTH * 3 / 4);
      default:   return CW'(DEPTH * 7 / 8);
    endcase
  endfunction

  logic [CW-1:0] tx_lvl, rx_lvl;
  assign tx_lvl = level_of(level_sel[SEL_W-1:0]);
  assign rx_lvl = level_of(level_sel[2*SEL_W-1:SEL_W]);

  assign tx_empty = (tx_count == '0);
  assign tx_full  = (tx_count == CW'(DEPTH));
  assign rx_empty = (rx_count == '0);
  assign rx_full  = (rx_count == CW'(DEPTH));
  assign tx_trig  = (tx_count <= tx_lvl);
  assign rx_trig  = (rx_count >= rx_lvl);

  logic tx_wr, tx_rd, rx_wr, rx_rd;
  assign tx_wr = tx_push && !tx_full;
  assign tx_rd = tx_pop  && !tx_empty;
  assign rx_wr = rx_push && !rx_full;
  assign rx_rd = rx_pop  && !rx_empty;

  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [RX_W-1:0]   rx_mem [DEPTH];
  logic [AW-1:0]     tx_wp, tx_rp, rx_wp, rx_rp;

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp] <= tx_wdata;
    if (rx_wr) rx_mem[rx_wp] <= {rx_werr, rx_wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0; tx_rdata <= '0; tx_ovf <= 1'b0;
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0; rx_rdata <= '0; rx_ovf <= 1'b0;
    end else begin
      tx_ovf   <= tx_push && tx_full;
      rx_ovf   <= rx_push && rx_full;
      tx_count <= tx_count + CW'(tx_wr) - CW'(tx_rd);
      rx_count <= rx_count + CW'(rx_wr) - CW'(rx_rd);
      if (tx_wr) tx_wp <= tx_wp + 1'b1;
      if (rx_wr) rx_wp <= rx_wp + 1'b1;
      if (tx_rd) begin
        tx_rdata <= tx_mem[tx_rp];
        tx_rp    <= tx_rp + 1'b1;
      end
      if (rx_rd) begin
        rx_rdata <= rx_mem[rx_rp];
        rx_rp    <= rx_rp + 1'b1;
      end
    end
  end

  AST_TX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(tx_empty && tx_full)); // R4
  AST_RX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rx_empty && rx_full)); // R4
  AST_TX_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && !tx_full && !tx_pop |=> tx_count == $past(tx_count) + 1'b1); // R2
  AST_RX_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rx_full && !rx_pop |=> rx_count == $past(rx_count) + 1'b1); // R2
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && tx_full && !tx_pop |=> tx_full && tx_ovf); // R8
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !rx_pop |=> rx_full && rx_ovf); // R8
  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf && !$past(tx_push) |-> 1'b0); // R8
  AST_RX_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && rx_empty && !rx_push |=> rx_empty && $stable(rx_rdata)); // R9
  AST_TX_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop && tx_empty && !tx_push |=> tx_empty && $stable(tx_rdata)); // R9
  AST_TX_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && tx_pop && !tx_empty && !tx_full |=> $stable(tx_count)); // R10
endmodule

// File: tb/serial_fifo_pair_bench.sv
module serial_fifo_pair_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] level_sel = '0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0;
  logic [3:0] rx_werr = '0;
  logic [7:0] tx_rdata;
  logic [11:0] rx_rdata;
  logic [4:0] tx_count, rx_count;
  logic tx_empty, tx_full, tx_trig, tx_ovf, rx_empty, rx_full, rx_trig, rx_ovf;

  serial_fifo_pair u_serial_fifo_pair (
    .clk(clk), .rst_n(rst_n), .level_sel(level_sel),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full), .tx_trig(tx_trig), .tx_ovf(tx_ovf),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_werr(rx_werr), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full), .rx_trig(rx_trig), .rx_ovf(rx_ovf)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0]  tq[$];
  logic [11:0] rq[$];
  logic [7:0]  exp_tx_q = '0;
  logic [11:0] exp_rx_q = '0;
  bit exp_tx_ovf = 0, exp_rx_ovf = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lvl(logic [2:0] code);
    case (code)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      default: return 14;
    endcase
  endfunction

  task automatic check_all(string req);
    chk(req, "tx_count", tx_count, tq.size());
    chk(req, "rx_count", rx_count, rq.size());
    chk("R4", "tx_empty", tx_empty, tq.size() == 0);
    chk("R4", "tx_full", tx_full, tq.size() == 16);
    chk("R4", "rx_empty", rx_empty, rq.size() == 0);
    chk("R4", "rx_full", rx_full, rq.size() == 16);
    chk("R7", "tx_trig", tx_trig, tq.size() <= lvl(level_sel[2:0]));
    chk("R6", "rx_trig", rx_trig, rq.size() >= lvl(level_sel[5:3]));
    chk(req, "tx_rdata", tx_rdata, exp_tx_q);
    chk(req, "rx_rdata", rx_rdata, exp_rx_q);
    chk("R8", "tx_ovf", tx_ovf, exp_tx_ovf);
    chk("R8", "rx_ovf", rx_ovf, exp_rx_ovf);
  endtask

  task automatic op(string req, bit tpu, logic [7:0] td, bit tpo,
                    bit rpu, logic [7:0] rd, logic [3:0] re, bit rpo);
    tx_push = tpu; tx_wdata = td; tx_pop = tpo;
    rx_push = rpu; rx_wdata = rd; rx_werr = re; rx_pop = rpo;
    @(posedge clk); #1;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    begin
      bit tpush_ok = tpu && tq.size() < 16;
      bit rpush_ok = rpu && rq.size() < 16;
      exp_tx_ovf = tpu && tq.size() == 16;
      exp_rx_ovf = rpu && rq.size() == 16;
      if (tpo && tq.size() > 0) exp_tx_q = tq.pop_front();
      if (rpo && rq.size() > 0) exp_rx_q = rq.pop_front();
      if (tpush_ok) tq.push_back(td);
      if (rpush_ok) rq.push_back({re, rd});
    end
    check_all(req);
  endtask

  task automatic t_reset;
    chk("R1", "tx_count", tx_count, 0);
    chk("R1", "rx_empty", rx_empty, 1);
    chk("R1", "rx_rdata", rx_rdata, 0);
    @(posedge clk); #1; rst_n = 1;
    @(posedge clk); #1;
    check_all("R1");
  endtask

  task automatic t_fill_drain;
    level_sel = 6'o00;
    for (int i = 0; i < 16; i++) op("R2", 1, 8'(8'h30 + i), 0, 1, 8'(8'hA0 + i), 4'(i), 0);
    op("R8", 1, 8'hEE, 0, 1, 8'hEE, 4'hF, 0);
    op("R8", 1, 8'hDD, 1, 1, 8'hDD, 4'h1, 1);
    op("R8", 0, 8'h00, 0, 0, 8'h00, 4'h0, 0);
    for (int i = 0; i < 16; i++) op("R2", 0, 8'h00, 1, 0, 8'h00, 4'h0, 1);
    op("R9", 0, 8'h00, 1, 0, 8'h00, 4'h0, 1);
    op("R9", 0, 8'h00, 1, 0, 8'h00, 4'h0, 1);
  endtask

  task automatic t_rx_fields;
    op("R3", 0, 8'h00, 0, 1, 8'h5A, 4'b1000, 0);
    op("R3", 0, 8'h00, 0, 1, 8'hC3, 4'b0100, 0);
    op("R3", 0, 8'h00, 0, 1, 8'h01, 4'b0010, 0);
    op("R3", 0, 8'h00, 0, 1, 8'hFE, 4'b0001, 0);
    for (int i = 0; i < 4; i++) begin
      op("R3", 0, 8'h00, 0, 0, 8'h00, 4'h0, 1);
      chk("R3", "rx_err_field", rx_rdata[11:8], 4'b1000 >> i);
    end
  endtask

  task automatic t_levels;
    for (int c = 0; c < 8; c++) begin
      level_sel = {3'(7 - c), 3'(c)};
      #1;
      check_all("R5");
      chk("R5", "tx_trig_empty", tx_trig, 1);
      for (int i = 0; i < 16; i++) op("R5", 1, 8'(i * 3), 0, 1, 8'(i * 5), 4'(c), 0);
      for (int i = 0; i < 16; i++) op("R5", 0, 8'h00, 1, 0, 8'h00, 4'h0, 1);
    end
    level_sel = 6'o00; #1;
    check_all("R5");
  endtask

  task automatic t_simultaneous;
    for (int i = 0; i < 5; i++) op("R10", 1, 8'(8'h70 + i), 0, 1, 8'(8'h90 + i), 4'h2, 0);
    for (int i = 0; i < 8; i++) op("R10", 1, 8'(8'h10 + i), 1, 1, 8'(8'h20 + i), 4'h4, 1);
    op("R10", 1, 8'h55, 1, 1, 8'h66, 4'h0, 0);
    op("R10", 0, 8'h00, 0, 1, 8'h77, 4'h8, 1);
    while (tq.size() > 0 || rq.size() > 0) op("R2", 0, 8'h00, 1, 0, 8'h00, 4'h0, 1);
    op("R10", 1, 8'hAB, 1, 1, 8'hCD, 4'h3, 1);
  endtask

  initial begin
    #5;
    t_reset();
    t_fill_drain();
    t_rx_fields();
    t_levels();
    t_simultaneous();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule